// File: doc/BRIEF.md
# Programmable Tick Accumulator

This block produces a periodic tick from a free-running phase-style accumulator. A 32-bit step value reaches the block as two 16-bit halves, each written into its own holding register by a dedicated write strobe. A registered active-low load request then copies the assembled holding value into the working step register. On every clock the accumulator adds the working step to its own value and wraps modulo 2^32. The carry out of that addition is registered and presented as an active-low tick, so the tick rate is step / 2^32 times the clock rate.

An active-low initialise input, also registered, cuts the accumulator's feedback path for one addition, so the next sum is the step alone. The same input forces the working step register to load from the holding registers. All control inputs are sampled on one rising edge and act on the next, which gives a two-edge latency from a request to its effect.

Top module: `tick_accum`

## Requirements
- R1: While rst_ni is low, tick_no is 1 and the holding registers, working step and accumulator are zero; after reset with no load, no tick occurs.
- R2: A write with wr_lo_i high stores wr_data_i into step bits 15:0 of the holding value only; wr_hi_i stores it into bits 31:16 only; both strobes high store the same word into both halves.
- R3: Writing the holding registers without a load request has no effect on the tick rate.
- R4: inc_load_ni low at rising edge N makes the working step take the holding value at edge N+1; the new step first enters the sum at edge N+2.
- R5: At every edge the accumulator becomes (accumulator + step) mod 2^32.
- R6: init_ni low at edge N makes the addition at edge N+1 use zero instead of the accumulator value, and also loads the working step from the holding value at edge N+1.
- R7: tick_no is 0 for exactly the clock cycle after an edge whose addition carried out of bit 31, and 1 otherwise.
- R8: With 0x40000000 in the holding value, init_ni low for one cycle sampled at edge E0 and the working step previously zero, tick_no is low after edges E5, E9, E13 and high after every other edge E1..E13.
- R9: inc_load_ni held low reloads the working step on every edge, so a holding change reaches the sum two edges after it is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_lo_i | input | 1 | Write strobe for the low half of the holding value |
| wr_hi_i | input | 1 | Write strobe for the high half of the holding value |
| wr_data_i | input | 16 | Half-word write data |
| inc_load_ni | input | 1 | Load request for the working step, active low, registered |
| init_ni | input | 1 | Initialise: zero feedback and load step, active low, registered |
| tick_no | output | 1 | Registered carry tick, active low |

## Verification
The hardest situation to reach is the exact alignment of a step change against the running accumulator: the only visible output is the carry, so a step register loaded one edge early or late shows only as a shift of a later tick. The stimulus reaches it by changing the step while ticks are already flowing at a known rate, with single-cycle load pulses, continuous load and initialise, and comparing every cycle's tick with a cycle-accurate model built from the requirements. A quarter-scale step after initialise pins the absolute tick positions, and an all-ones step exercises wrap on almost every edge.

// File: rtl/tick_accum_pkg.sv
package tick_accum_pkg;
  localparam int unsigned ACC_W  = 32;
  localparam int unsigned HALF_W = ACC_W / 2;
  localparam int unsigned N_HALF = 2;

  typedef logic [ACC_W-1:0]  acc_t;
  typedef logic [HALF_W-1:0] half_t;

  typedef struct packed {
    logic load;
    logic init;
  } ctrl_t;
endpackage

// File: rtl/tick_hold_regs.sv
module tick_hold_regs
  import tick_accum_pkg::*;
#(
  parameter int unsigned HW = HALF_W,
  parameter int unsigned NH = N_HALF,
  localparam int unsigned TW = HW * NH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NH-1:0] wr_i,
  input  logic [HW-1:0] data_i,
  output logic [TW-1:0] hold_o
);
  for (genvar g = 0; g < NH; g++) begin : g_half
    logic [HW-1:0] half_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     half_q <= '0;
      else if (wr_i[g]) half_q <= data_i;
    end
    assign hold_o[g*HW +: HW] = half_q;
  end

  AST_LO_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i[0] && !wr_i[NH-1]) |=> hold_o[TW-1 -: HW] == $past(hold_o[TW-1 -: HW])); // R2
endmodule

// File: rtl/tick_ctrl_sync.sv
module tick_ctrl_sync
  import tick_accum_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_ni,
  input  logic  init_ni,
  output ctrl_t ctrl_o
);
  ctrl_t ctrl_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else begin
      ctrl_q.load <= ~load_ni;
      ctrl_q.init <= ~init_ni;
    end
  end
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/tick_accum_core.sv
module tick_accum_core
  import tick_accum_pkg::*;
#(
  parameter int unsigned W = ACC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  ctrl_t        ctrl_i,
  input  logic [W-1:0] hold_i,
  output logic         tick_no
);
  logic [W-1:0] inc_q, acc_q, fb;
  logic [W:0]   sum;
  logic         tick_q;

  // initialise also forces the step register to take the holding value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        inc_q <= '0;
    else if (ctrl_i.load || ctrl_i.init) inc_q <= hold_i;
  end

  assign fb  = ctrl_i.init ? '0 : acc_q;
  assign sum = {1'b0, fb} + {1'b0, inc_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      acc_q  <= sum[W-1:0];
      tick_q <= ~sum[W];
    end
  end
  assign tick_no = tick_q;

  AST_STEP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.load && !ctrl_i.init) |=> $stable(inc_q)); // R3
  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.load |=> inc_q == $past(hold_i)); // R4
  AST_INIT_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.init |=> tick_no); // R6
  AST_TICK_IS_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_no |-> acc_q < $past(inc_q)); // R7
endmodule

// File: rtl/tick_accum.sv
module tick_accum
  import tick_accum_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic              inc_load_ni,
  input  logic              init_ni,
  output logic              tick_no
);
  acc_t  hold;
  ctrl_t ctrl;

  tick_hold_regs #(.HW(HALF_W), .NH(N_HALF)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   ({wr_hi_i, wr_lo_i}),
    .data_i (wr_data_i),
    .hold_o (hold)
  );

  tick_ctrl_sync i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_ni (inc_load_ni),
    .init_ni (init_ni),
    .ctrl_o  (ctrl)
  );

  tick_accum_core #(.W(ACC_W)) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctrl_i  (ctrl),
    .hold_i  (hold),
    .tick_no (tick_no)
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i) !rst_ni |=> tick_no); // R1
endmodule

// File: tb/test_tick_accum.sv
module test_tick_accum;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_lo = 1'b0, wr_hi = 1'b0;
  logic [15:0] wr_data = '0;
  logic        load_n = 1'b1, init_n = 1'b1;
  logic        tick_n;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_accum i_tick_accum (
    .clk_i(clk), .rst_ni(rst_n), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wr_data_i(wr_data), .inc_load_ni(load_n), .init_ni(init_n), .tick_no(tick_n)
  );

  // cycle model derived from the requirements
  logic [31:0] m_hold, m_inc, m_acc;
  logic        m_load, m_init, m_tick;
  logic [32:0] m_sum;
  always_comb m_sum = {1'b0, (m_init ? 32'h0 : m_acc)} + {1'b0, m_inc};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold <= '0; m_inc <= '0; m_acc <= '0;
      m_load <= 1'b0; m_init <= 1'b0; m_tick <= 1'b1;
    end else begin
      if (wr_lo) m_hold[15:0]  <= wr_data;
      if (wr_hi) m_hold[31:16] <= wr_data;
      m_load <= ~load_n;
      m_init <= ~init_n;
      if (m_load || m_init) m_inc <= m_hold;
      m_acc  <= m_sum[31:0];
      m_tick <= ~m_sum[32];
    end
  end

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: tick_no actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic run_cmp(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tick_n, m_tick, req);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_lo = 0; wr_hi = 0; load_n = 1; init_n = 1;
    #1 check(tick_n, 1'b1, "R1");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_step(input logic [31:0] v);
    @(negedge clk); wr_lo = 1; wr_data = v[15:0];
    @(negedge clk); wr_lo = 0; wr_hi = 1; wr_data = v[31:16];
    @(negedge clk); wr_hi = 0;
  endtask

  task automatic pulse_load();
    @(negedge clk); load_n = 0;
    @(negedge clk); load_n = 1;
  endtask

  task automatic t_reset_idle();
    do_reset();
    write_step(32'h4000_0000);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(tick_n, 1'b1, "R1 no tick without load");
    end
  endtask

  task automatic t_quarter_after_init();
    do_reset();
    write_step(32'h4000_0000);
    @(negedge clk); init_n = 0;
    @(posedge clk);            // E0
    @(negedge clk); init_n = 1;
    check(tick_n, 1'b1, "R8 E0");
    for (int k = 1; k <= 13; k++) begin
      @(negedge clk);
      check(tick_n, (k == 5 || k == 9 || k == 13) ? 1'b0 : 1'b1, "R8");
    end
    run_cmp(20, "R6 R8");
  endtask

  task automatic t_hold_no_effect();
    @(negedge clk); wr_hi = 1; wr_data = 16'h8000;
    @(negedge clk); wr_hi = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check(tick_n, m_tick, "R3");
    end
  endtask

  task automatic t_load_latency();
    pulse_load();
    run_cmp(24, "R4");
  endtask

  task automatic t_half_writes();
    @(negedge clk); wr_lo = 1; wr_data = 16'h1234;
    @(negedge clk); wr_lo = 0;
    pulse_load();
    run_cmp(20, "R2 low half");
    @(negedge clk); wr_lo = 1; wr_hi = 1; wr_data = 16'h2000;
    @(negedge clk); wr_lo = 0; wr_hi = 0;
    pulse_load();
    run_cmp(40, "R2 both halves");
  endtask

  task automatic t_continuous_load();
    @(negedge clk); load_n = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); wr_hi = 1; wr_data = 16'h1000 << (i % 3);
      check(tick_n, m_tick, "R9");
    end
    @(negedge clk); wr_hi = 0; load_n = 1;
    run_cmp(30, "R9");
  endtask

  task automatic t_wrap_all_ones();
    write_step(32'hFFFF_FFFF);
    @(negedge clk); init_n = 0; load_n = 0;
    @(negedge clk); init_n = 1; load_n = 1;
    run_cmp(40, "R5 R7 wrap");
  endtask

  task automatic t_init_mid_run();
    write_step(32'h3000_0000);
    pulse_load();
    run_cmp(7, "R5");
    @(negedge clk); init_n = 0;
    @(negedge clk); init_n = 1;
    run_cmp(30, "R6 mid-run");
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset_idle();
    t_quarter_after_init();
    t_hold_no_effect();
    t_load_latency();
    t_half_writes();
    t_continuous_load();
    t_wrap_all_ones();
    t_init_mid_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule